// File: doc/BRIEF.md
# USB Receive Endpoint Control and Status Register

This block holds the 8-bit control and status byte of one USB device receive (OUT) endpoint and tracks how many packet slots of its receive FIFO are in use. The FIFO holds one packet, or two when the double-buffer parameter is set. The packet data itself is stored elsewhere. This block only counts occupied slots and reports whether a packet is waiting to be read and whether every slot is taken.

Software reaches the byte through a simple write strobe and a combinational read value. The packet engine reports four kinds of event, each a single-cycle pulse:

- a packet was stored;
- a packet was refused because no slot was free;
- the received packet had a CRC or bit-stuff error;
- a STALL handshake went out.

The block drives the endpoint's data toggle, a stall request and a one-cycle interrupt pulse. It takes an input that selects isochronous or bulk behaviour.

Top module: `rxEpCsr`

## Requirements
- R1: After reset the read value is 0x00, the data toggle is 0, the stall request is 0 and the interrupt is 0.
- R2: A stored-packet pulse with a free slot raises packet-ready (bit 0) at the next edge. It also makes the interrupt high for exactly the following cycle.
- R3: Writing a byte with bit 0 = 0 while packet-ready is 1 frees one slot. With two packets held, bit 0 stays 1 and bit 1 falls.
- R4: Writing bit 4 = 1 discards one waiting packet. Bit 4 always reads 0. With two packets held, two such writes are needed before bit 0 reads 0.
- R5: Bit 1 reads 1 exactly when every slot is occupied. A stored-packet pulse while full changes no slot count and no toggle.
- R6: A refused-packet pulse in isochronous mode sets overrun (bit 2). A write with bit 2 = 0 clears it. In bulk mode the event does not set it and bit 2 reads 0.
- R7: An error pulse in isochronous mode sets data-error (bit 3). Data-error is cleared whenever a slot is freed. In bulk mode bit 3 reads 0 and the event does not set it.
- R8: A STALL-sent pulse sets bit 6. A write with bit 6 = 0 clears it.
- R9: Bit 5 holds the written value and drives the stall-request output directly.
- R10: The data toggle flips on every accepted packet. A write with bit 7 = 1 forces it to 0. Bit 7 always reads 0.
- R11: Writing 1 to bit 0, bit 2 or bit 6 leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Current register value |
| pktStored | input | 1 | Packet engine stored a packet |
| pktRejected | input | 1 | Packet refused, no free slot |
| pktCrcErr | input | 1 | Received packet had CRC or bit-stuff error |
| stallSent | input | 1 | STALL handshake transmitted |
| isoMode | input | 1 | 1 = isochronous, 0 = bulk |
| dataToggle | output | 1 | Current endpoint data toggle |
| stallReq | output | 1 | Answer with STALL handshakes |
| irq | output | 1 | One-cycle pulse per accepted packet |

## Verification
A wrong slot count appears in bits 0 and 1 of the read value one edge after the store or free that caused it. A count that went wrong while full becomes visible only after the next free: for example, a lost second packet makes bit 0 fall after a single clear instead of two. Sticky-flag errors show on the very next read. Flags from the wrong mode stay hidden while bulk mode masks them, so the bench switches back to isochronous mode to expose them.

// File: rtl/rxEpPkg.sv
package rxEpPkg;
  // Strobes from the register control to the slot datapath
  typedef struct packed {
    logic pop;        // free one occupied slot
    logic clrToggle;  // force data toggle to 0
  } slotCmd_t;
endpackage

// File: rtl/rxEpSlots.sv
module rxEpSlots
  import rxEpPkg::*;
#(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  slotCmd_t cmd,
  input  logic     pktStored,
  output logic     ready,
  output logic     full,
  output logic     irq,
  output logic     dataToggle
);
  localparam int DEPTH = DOUBLE_BUF ? 2 : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          accept;

  assign full   = (count == CW'(DEPTH));
  assign ready  = (count != '0);
  assign accept = pktStored && !full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      irq        <= 1'b0;
      dataToggle <= 1'b0;
    end else begin
      irq <= accept;
      if (accept && !(cmd.pop && ready))
        count <= count + 1'b1;
      else if (!accept && cmd.pop && ready)
        count <= count - 1'b1;
      if (cmd.clrToggle)
        dataToggle <= 1'b0;
      else if (accept)
        dataToggle <= ~dataToggle;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  // R2
  store_sets_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktStored && !full && !cmd.pop) |=> ready);
  // R2
  irq_after_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(pktStored));
  // R10
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrToggle |=> !dataToggle);
endmodule

// File: rtl/rxEpCtrl.sv
module rxEpCtrl
  import rxEpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       isoMode,
  input  logic       ready,
  input  logic       pktRejected,
  input  logic       pktCrcErr,
  input  logic       stallSent,
  output slotCmd_t   cmd,
  output logic       sentStall,
  output logic       sendStall,
  output logic       overrun,
  output logic       dataError
);
  logic unusedBits;
  assign unusedBits = ^{wrData[3], wrData[1]};

  // One free per write, whether by clear or by flush
  assign cmd.pop       = wrEn && ready && (!wrData[0] || wrData[4]);
  assign cmd.clrToggle = wrEn && wrData[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentStall <= 1'b0;
      sendStall <= 1'b0;
      overrun   <= 1'b0;
      dataError <= 1'b0;
    end else begin
      if (stallSent)               sentStall <= 1'b1;
      else if (wrEn && !wrData[6]) sentStall <= 1'b0;
      if (wrEn) sendStall <= wrData[5];
      if (pktRejected && isoMode)  overrun <= 1'b1;
      else if (wrEn && !wrData[2]) overrun <= 1'b0;
      if (pktCrcErr && isoMode)    dataError <= 1'b1;
      else if (cmd.pop)            dataError <= 1'b0;
    end
  end

  // R8
  stall_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallSent |=> sentStall);
  // R6
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(isoMode && pktRejected));
  // R7
  derr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataError) |-> $past(isoMode && pktCrcErr));
  // R9
  send_stall_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[5]) |=> !sendStall);
endmodule

// File: rtl/rxEpCsr.sv
module rxEpCsr
  import rxEpPkg::*;
#(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       pktStored,
  input  logic       pktRejected,
  input  logic       pktCrcErr,
  input  logic       stallSent,
  input  logic       isoMode,
  output logic       dataToggle,
  output logic       stallReq,
  output logic       irq
);
  slotCmd_t cmd;
  logic ready, full, sentStall, sendStall, overrun, dataError;

  rxEpCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrData(regWrData),
    .isoMode(isoMode), .ready(ready), .pktRejected(pktRejected),
    .pktCrcErr(pktCrcErr), .stallSent(stallSent), .cmd(cmd),
    .sentStall(sentStall), .sendStall(sendStall), .overrun(overrun),
    .dataError(dataError)
  );

  rxEpSlots #(.DOUBLE_BUF(DOUBLE_BUF)) uSlots (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pktStored(pktStored),
    .ready(ready), .full(full), .irq(irq), .dataToggle(dataToggle)
  );

  assign stallReq  = sendStall;
  // Command bits 7 and 4 act at once and read back 0
  assign regRdData = {1'b0, sentStall, sendStall, 1'b0,
                      dataError & isoMode, overrun & isoMode, full, ready};
endmodule

// File: tb/rxEpCsr_test.sv
module rxEpCsr_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic pktStored = 1'b0, pktRejected = 1'b0, pktCrcErr = 1'b0, stallSent = 1'b0;
  logic isoMode = 1'b1;
  logic [7:0] regRdData;
  logic dataToggle, stallReq, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxEpCsr uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .pktStored(pktStored), .pktRejected(pktRejected),
    .pktCrcErr(pktCrcErr), .stallSent(stallSent), .isoMode(isoMode),
    .dataToggle(dataToggle), .stallReq(stallReq), .irq(irq)
  );

  // {wr, wdata[8], store, reject, crc, stall, expRd[8], expIrq, expToggle}
  localparam int N = 17;
  localparam logic [22:0] tbl [0:N-1] = '{
    {1'b0, 8'h00, 4'b1000, 8'h01, 2'b11},  // R2 first packet
    {1'b0, 8'h00, 4'b1000, 8'h03, 2'b10},  // R5 both slots full
    {1'b0, 8'h00, 4'b1100, 8'h07, 2'b00},  // R6 R5 store while full refused
    {1'b1, 8'h45, 4'b0000, 8'h07, 2'b00},  // R11 ones change nothing
    {1'b0, 8'h00, 4'b0010, 8'h0F, 2'b00},  // R7 error flagged
    {1'b1, 8'h0C, 4'b0000, 8'h05, 2'b00},  // R3 R7 one slot freed
    {1'b1, 8'h00, 4'b0000, 8'h00, 2'b00},  // R3 R6 last slot freed
    {1'b0, 8'h00, 4'b0001, 8'h40, 2'b00},  // R8 stall sent
    {1'b1, 8'h60, 4'b0000, 8'h60, 2'b00},  // R9 R11 stall on
    {1'b1, 8'h20, 4'b0000, 8'h20, 2'b00},  // R8 sent flag cleared
    {1'b0, 8'h00, 4'b1000, 8'h21, 2'b11},  // R2 R10
    {1'b0, 8'h00, 4'b1000, 8'h23, 2'b10},  // R10 toggle back
    {1'b1, 8'h31, 4'b0000, 8'h21, 2'b00},  // R4 first flush
    {1'b1, 8'h31, 4'b0000, 8'h20, 2'b00},  // R4 second flush
    {1'b0, 8'h00, 4'b1000, 8'h21, 2'b11},  // R10 toggle 1
    {1'b1, 8'hA1, 4'b0000, 8'h21, 2'b00},  // R10 clear toggle
    {1'b1, 8'h01, 4'b0000, 8'h01, 2'b00}   // R9 stall off
  };
  localparam int reqOf [0:N-1] = '{2, 5, 6, 11, 7, 3, 3, 8, 9, 8, 10, 10, 4, 4, 10, 10, 9};

  task automatic apply(input logic wr, input logic [7:0] d,
                       input logic st, input logic rj, input logic cr, input logic sl);
    regWrEn = wr; regWrData = d;
    pktStored = st; pktRejected = rj; pktCrcErr = cr; stallSent = sl;
    @(posedge clk);
    #1;
    regWrEn = 1'b0; regWrData = 8'h00;
    pktStored = 1'b0; pktRejected = 1'b0; pktCrcErr = 1'b0; stallSent = 1'b0;
  endtask

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    check(1, regRdData, 8'h00);
    check(1, {5'b0, dataToggle, stallReq, irq}, 8'h00);

    for (int i = 0; i < N; i++) begin
      apply(tbl[i][22], tbl[i][21:14], tbl[i][13], tbl[i][12], tbl[i][11], tbl[i][10]);
      check(reqOf[i], regRdData, tbl[i][9:2]);
      check(reqOf[i], {6'b0, irq, dataToggle}, {6'b0, tbl[i][1:0]});
    end

    // R9 stall request follows bit 5
    apply(1'b1, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0);
    check(9, {7'b0, stallReq}, 8'h01);
    apply(1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
    check(9, {7'b0, stallReq}, 8'h00);

    // R6 R7 bulk mode: events ignored, bits masked
    apply(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    check(3, regRdData, 8'h00);
    isoMode = 1'b0;
    apply(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    check(6, regRdData, 8'h00);
    apply(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    check(7, regRdData, 8'h01);
    isoMode = 1'b1;
    #1;
    check(6, regRdData, 8'h01);
    // R7 error in ISO then masked by bulk mode
    apply(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    check(7, regRdData, 8'h09);
    isoMode = 1'b0;
    #1;
    check(7, regRdData, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule